// File: doc/BRIEF.md
# Clock Gate Bank with Masked Writes

This block holds the stop bits for a bank of gated clocks and drives one enable line per clock. The stop bits live in a run of consecutive 32-bit words, sixteen gates to a word. Each gate owns a pair of adjacent bits. The low bit of the pair is the stored stop value. The high bit is a per-gate write strobe that is never stored. Software can therefore start or stop any single clock with one plain store, with no read-modify-write and no lock, and the other gates in the same word are left alone.

Any gate can be fixed at build time as read-only. Such a gate keeps its reset value forever. The reset value of every gate is also a build parameter. Reads return the stored stop bits one cycle after the request. Each enable output is the registered inverse of its stop bit, so it is ready to drive a glitch-free gating cell placed outside this block.

Top module: `clkgate_bank`

## Requirements
- R1: After reset, each gate's stop bit equals its bit in `STOP_RESET`, `gate_en` equals the bitwise inverse of `STOP_RESET`, and `rdata` and `rvalid` are 0.
- R2: A write that puts pair value 2'b10 (strobe bit 1, value bit 0) on gate g's pair clears g's stop bit, which starts the clock.
- R3: A write that puts pair value 2'b11 on gate g's pair sets g's stop bit, which stops the clock.
- R4: When a pair's strobe bit (the upper bit of the pair) is 0, that gate's stop bit is unchanged whatever its value bit holds.
- R5: A gate marked in `RO_MASK` never changes its stop bit or its enable output after reset.
- R6: A read with `rd_en` high returns data on `rdata` with `rvalid` high one cycle later. Stop bits appear at the even positions 2s. Odd positions, and the slots of gate numbers not below `NUM_GATES`, read as 0.
- R7: Word k sits at byte address `BASE_ADDR + 4*k`. Gate g is in word g/16, with its stop bit at position 2*(g%16) and its strobe at 2*(g%16)+1. A write to an address that is misaligned, below the base, or past the last word changes nothing. A read of such an address returns 0.
- R8: `gate_en[g]` follows a change of g's stop bit one clock after the write edge. It is the inverse of the stop bit.
- R9: When a read and a write reach the same word in the same cycle, the read returns the stop bits held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request, applied at this rising edge |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Byte address shared by reads and writes |
| wdata | input | 32 | Write data: strobe/value bit pairs |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | High the cycle after `rd_en` |
| gate_en | output | NUM_GATES | Per-clock enable, 1 = clock running |

## Verification
The bound checker watches four properties on every cycle:
- read-only enables never move;
- `rvalid` tracks `rd_en` one cycle later;
- odd read bits and misaligned reads stay zero;
- a cycle with no write leaves the enables stable on the cycle after next.

Some behaviours need a reference model and only the bench's scenarios show them. These are the per-gate effect of the 10 and 11 pair codes, the isolation of neighbours whose strobe is 0, the rejection of out-of-range addresses, and the read-before-write ordering. The bench covers them with directed cases and with random masked writes checked against a bench model.

// File: rtl/clkgate_bank_pkg.sv
package clkgate_bank_pkg;
    localparam int DATA_W         = 32;
    localparam int GATES_PER_WORD = DATA_W / 2;

    typedef logic [GATES_PER_WORD-1:0] slot_vec_t;

    function automatic int words_for(input int gates);
        return (gates + GATES_PER_WORD - 1) / GATES_PER_WORD;
    endfunction

    function automatic int idx_width(input int words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction
endpackage

// File: rtl/clkgate_bank_decode.sv
module clkgate_bank_decode
    import clkgate_bank_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h54,
    parameter int NUM_WORDS = 3,
    localparam int IDX_W    = idx_width(NUM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  word_idx
);
    localparam logic [ADDR_W-1:0] BASE_V  = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] WORDS_V = ADDR_W'(NUM_WORDS);

    logic [ADDR_W-1:0] offs;

    always_comb begin
        offs     = addr - BASE_V;
        hit      = (addr >= BASE_V) && (offs[1:0] == 2'b00)
                   && ({2'b00, offs[ADDR_W-1:2]} < WORDS_V);
        word_idx = offs[IDX_W+1:2];
    end
endmodule

// File: rtl/clkgate_bank_word.sv
module clkgate_bank_word
    import clkgate_bank_pkg::*;
#(
    parameter int                   WORD_IDX   = 0,
    parameter int                   NUM_GATES  = 40,
    parameter logic [NUM_GATES-1:0] RO_MASK    = '0,
    parameter logic [NUM_GATES-1:0] STOP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output slot_vec_t         stop_o,
    output slot_vec_t         en_o
);
    logic wdata_unused;
    assign wdata_unused = ^wdata;

    for (genvar s = 0; s < GATES_PER_WORD; s++) begin : g_slot
        localparam int G = WORD_IDX * GATES_PER_WORD + s;
        if (G >= NUM_GATES) begin : g_absent
            assign stop_o[s] = 1'b0;
            assign en_o[s]   = 1'b0;
        end else if (RO_MASK[G]) begin : g_fixed
            assign stop_o[s] = STOP_RESET[G];
            assign en_o[s]   = ~STOP_RESET[G];
        end else begin : g_live
            logic stop_q;
            logic en_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stop_q <= STOP_RESET[G];
                end else if (wr_sel && wdata[2*s+1]) begin
                    stop_q <= wdata[2*s];
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en_q <= ~STOP_RESET[G];
                end else begin
                    en_q <= ~stop_q;
                end
            end
            assign stop_o[s] = stop_q;
            assign en_o[s]   = en_q;
        end
    end
endmodule

// File: rtl/clkgate_bank_rdmux.sv
module clkgate_bank_rdmux
    import clkgate_bank_pkg::*;
#(
    parameter int NUM_WORDS = 3,
    localparam int IDX_W    = idx_width(NUM_WORDS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic                           hit,
    input  logic [IDX_W-1:0]               word_idx,
    input  slot_vec_t [NUM_WORDS-1:0]      stop_words,
    output logic [DATA_W-1:0]              rdata,
    output logic                           rvalid
);
    slot_vec_t         sel_slots;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        sel_slots = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (hit && (word_idx == IDX_W'(w))) begin
                sel_slots = stop_words[w];
            end
        end
        rd_word = '0;
        for (int s = 0; s < GATES_PER_WORD; s++) begin
            rd_word[2*s] = sel_slots[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? rd_word : '0;
        end
    end
endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank
    import clkgate_bank_pkg::*;
#(
    parameter int                   ADDR_W     = 8,
    parameter int                   BASE_ADDR  = 'h54,
    parameter int                   NUM_GATES  = 40,
    parameter logic [NUM_GATES-1:0] RO_MASK    = 40'h00_0000_0030,
    parameter logic [NUM_GATES-1:0] STOP_RESET = 40'h80_0000_0020
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic                 rvalid,
    output logic [NUM_GATES-1:0] gate_en
);
    localparam int NUM_WORDS = words_for(NUM_GATES);
    localparam int IDX_W     = idx_width(NUM_WORDS);

    logic                      hit;
    logic [IDX_W-1:0]          word_idx;
    slot_vec_t [NUM_WORDS-1:0] stop_words;
    slot_vec_t [NUM_WORDS-1:0] en_words;
    logic                      en_unused;

    clkgate_bank_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .NUM_WORDS (NUM_WORDS)
    ) decode_i (
        .addr     (addr),
        .hit      (hit),
        .word_idx (word_idx)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic wr_sel;
        assign wr_sel = wr_en && hit && (word_idx == IDX_W'(w));
        clkgate_bank_word #(
            .WORD_IDX   (w),
            .NUM_GATES  (NUM_GATES),
            .RO_MASK    (RO_MASK),
            .STOP_RESET (STOP_RESET)
        ) word_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (wr_sel),
            .wdata  (wdata),
            .stop_o (stop_words[w]),
            .en_o   (en_words[w])
        );
    end

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_en
        assign gate_en[g] = en_words[g / GATES_PER_WORD][g % GATES_PER_WORD];
    end
    assign en_unused = ^en_words;

    clkgate_bank_rdmux #(
        .NUM_WORDS (NUM_WORDS)
    ) rdmux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .hit        (hit),
        .word_idx   (word_idx),
        .stop_words (stop_words),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );
endmodule

// File: rtl/clkgate_bank_checker.sv
module clkgate_bank_checker #(
    parameter int                   ADDR_W     = 8,
    parameter int                   NUM_GATES  = 40,
    parameter logic [NUM_GATES-1:0] RO_MASK    = '0,
    parameter logic [NUM_GATES-1:0] STOP_RESET = '0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [31:0]          rdata,
    input logic                 rvalid,
    input logic [NUM_GATES-1:0] gate_en
);
    localparam logic [31:0] ODD_BITS = 32'hAAAA_AAAA;

    // R5: read-only gates keep their reset enable value
    p_ro_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en & RO_MASK) == (~STOP_RESET & RO_MASK));

    // R6: response strobe one cycle after each read request
    p_rvalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    p_rvalid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

    // R6: strobe positions never read back as 1
    p_odd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> ((rdata & ODD_BITS) == 32'h0));

    // R7: misaligned reads return zero
    p_misaligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr[1:0] != 2'b00)) |=> (rdata == 32'h0));

    // R8: no write means no enable change after the register stage
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ##1 $stable(gate_en));
endmodule

bind clkgate_bank clkgate_bank_checker #(
    .ADDR_W     (ADDR_W),
    .NUM_GATES  (NUM_GATES),
    .RO_MASK    (RO_MASK),
    .STOP_RESET (STOP_RESET)
) checker_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .rvalid  (rvalid),
    .gate_en (gate_en)
);

// File: tb/clkgate_bank_tb_top.sv
module clkgate_bank_tb_top;
    localparam int             NG   = 40;
    localparam int             AW   = 8;
    localparam int             NW   = 3;
    localparam int             BASE = 'h54;
    localparam logic [NG-1:0]  RO   = 40'h00_0000_0030;
    localparam logic [NG-1:0]  SR   = 40'h80_0000_0020;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rvalid;
    logic [NG-1:0] gate_en;

    int            total = 0;
    int            bad = 0;
    bit            finished = 1'b0;
    logic [NG-1:0] stop_m;

    always #4 clk = ~clk;

    clkgate_bank #(
        .ADDR_W (AW), .BASE_ADDR (BASE), .NUM_GATES (NG),
        .RO_MASK (RO), .STOP_RESET (SR)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
        .addr (addr), .wdata (wdata), .rdata (rdata), .rvalid (rvalid),
        .gate_en (gate_en)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit b_hit(input logic [AW-1:0] a);
        int ai = int'(a);
        return (ai >= BASE) && (((ai - BASE) % 4) == 0) && (((ai - BASE) / 4) < NW);
    endfunction

    function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
        logic [31:0] r = '0;
        if (b_hit(a)) begin
            int w = (int'(a) - BASE) / 4;
            for (int s = 0; s < 16; s++) begin
                int g = w * 16 + s;
                if (g < NG) r[2*s] = stop_m[g];
            end
        end
        return r;
    endfunction

    function automatic void model_write(input logic [AW-1:0] a, input logic [31:0] d);
        if (b_hit(a)) begin
            int w = (int'(a) - BASE) / 4;
            for (int s = 0; s < 16; s++) begin
                int g = w * 16 + s;
                if (g < NG && d[2*s+1] && !RO[g]) stop_m[g] = d[2*s];
            end
        end
    endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        e = exp_word(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk(rvalid === 1'b1, {tag, " rvalid"}, 64'(rvalid), 64'd1);
        chk(rdata === e, {tag, " rdata"}, 64'(rdata), 64'(e));
    endtask

    task automatic en_chk(input string tag);
        @(negedge clk);
        chk(gate_en === ~stop_m, {tag, " gate_en"}, 64'(gate_en), 64'(~stop_m));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NG-1:0] prev_en;
        logic [31:0]   e;
        int            seed;
        seed = $urandom(32'h0C1C_6A7E);
        stop_m = SR;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(gate_en === ~SR, "R1 reset gate_en", 64'(gate_en), 64'(~SR));
        chk(rvalid === 1'b0, "R1 reset rvalid", 64'(rvalid), 64'd0);
        chk(rdata === 32'h0, "R1 reset rdata", 64'(rdata), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gate_en === ~SR, "R1 post-release gate_en", 64'(gate_en), 64'(~SR));
        rd_chk(AW'(BASE + 8), "R1 word2 readback");

        // R2, R8: start gate 39 (word 2, slot 7, pair 10)
        prev_en = gate_en;
        wr(AW'(BASE + 8), 32'h0000_8000);
        chk(gate_en === prev_en, "R8 enable lag", 64'(gate_en), 64'(prev_en));
        en_chk("R8 enable follows");
        chk(gate_en[39] === 1'b1, "R2 gate39 started", 64'(gate_en[39]), 64'd1);

        // R3: stop gate 3 (word 0, slot 3, pair 11)
        wr(AW'(BASE), 32'h0000_00C0);
        en_chk("R3 after stop");
        chk(gate_en[3] === 1'b0, "R3 gate3 stopped", 64'(gate_en[3]), 64'd0);
        rd_chk(AW'(BASE), "R3 word0 readback");

        // R4: value bits set, strobes clear
        wr(AW'(BASE), 32'h5555_5555);
        en_chk("R4 no strobe");
        rd_chk(AW'(BASE), "R4 word0 unchanged");

        // R5: read-only gates 4 and 5 ignore stop-all and start-all
        wr(AW'(BASE), 32'hFFFF_FFFF);
        en_chk("R5 stop all");
        chk(gate_en[5:4] === 2'b01, "R5 ro after stop-all", 64'(gate_en[5:4]), 64'd1);
        wr(AW'(BASE), 32'hAAAA_AAAA);
        en_chk("R5 start all");
        chk(gate_en[5:4] === 2'b01, "R5 ro after start-all", 64'(gate_en[5:4]), 64'd1);

        // R6: absent slots of the last word read 0
        wr(AW'(BASE + 8), 32'hFFFF_FFFF);
        rd_chk(AW'(BASE + 8), "R6 partial word");
        chk(rdata[31:16] === 16'h0, "R6 absent slots", 64'(rdata[31:16]), 64'd0);

        // R7: bad addresses
        wr(AW'(BASE + 1), 32'hFFFF_FFFF);
        wr(AW'(BASE + 4 * NW), 32'hFFFF_FFFF);
        wr(AW'(BASE - 4), 32'hFFFF_FFFF);
        en_chk("R7 bad writes ignored");
        rd_chk(AW'(BASE + 4), "R7 word1 intact");
        rd_chk(AW'(BASE + 2), "R7 misaligned read");
        rd_chk(AW'(BASE + 4 * NW), "R7 past-end read");
        rd_chk(AW'(BASE - 4), "R7 below-base read");

        // R9: read and write in one cycle
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = AW'(BASE + 4); wdata = 32'h0000_000F;
        e = exp_word(AW'(BASE + 4));
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk(rdata === e, "R9 read before write", 64'(rdata), 64'(e));
        model_write(AW'(BASE + 4), 32'h0000_000F);
        rd_chk(AW'(BASE + 4), "R9 write landed");

        // R2 R3 R4 R6 R7: random masked writes
        for (int i = 0; i < 250; i++) begin
            int          k = int'($urandom % 10);
            logic [AW-1:0] a;
            if (k < 8)       a = AW'(BASE + 4 * int'($urandom % NW));
            else if (k == 8) a = AW'(BASE + 1 + int'($urandom % 3));
            else             a = AW'(BASE + 4 * NW);
            wr(a, $urandom);
            en_chk("R2 random");
            rd_chk(AW'(BASE + 4 * int'($urandom % NW)), "R6 random read");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule